// File: doc/BRIEF.md
# Baud-Rate Generator Bank

This block holds a bank of independent programmable clock dividers, each producing a one-cycle tick that paces one serial channel. All generators count the same source clock, which is the engine core clock divided by two. Each generator is set up by one 32-bit control word written over a simple write port made of a strobe, an index and a data word. The control word carries an enable flag, a divide-by-16 prescale flag and a 12-bit field that holds the division ratio minus one. Writing a word restarts that generator's counters, so its phase is fixed by the write.

A combinational helper turns a requested rate and an oversampling multiplier into a ready-made control word. The nominal ratio is the source frequency divided by the product of rate and multiplier. If that ratio is larger than the field can hold, the helper selects the prescaler and divides the ratio by 16. Without the prescaler an odd ratio is rounded up to the next even value. Software reads the word from the helper and writes it back through the write port. Index numbering at the port runs from 1 to the number of generators. Any other index is refused and reported.

Top module: `brg_bank`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, every tick output and the reject flag are low, and every generator is disabled.
- R2: A write with index k in 1..16 loads generator k-1 (tick bit k-1). Bit 16 of the word is the enable, bit 0 the divide-by-16 flag and bits [12:1] the field F. All other bits have no effect.
- R3: An enabled generator with the prescale flag clear pulses its tick for one cycle every F+1 clocks. The first pulse is seen F+1 clocks after the write edge.
- R4: With the prescale flag set, the period becomes 16*(F+1) clocks, and the first pulse is seen 16*(F+1) clocks after the write edge.
- R5: A disabled generator emits no ticks and keeps its phase at zero.
- R6: A write to a generator restarts its phase from zero even when the word is unchanged. Other generators keep their phase.
- R7: A write with index 0 or above 16 changes no generator. The reject flag goes high for exactly the cycle after such a write.
- R8: The helper computes the ratio D = floor(SRC_HZ / (rate*mult)). If D > 4096 it sets bit 0 and uses floor(D/16) in place of D.
- R9: With the prescale flag clear, the helper raises an odd D by one. The word is bit 16 set, plus bit 0 as chosen, plus the low 12 bits of D-1 in bits [12:1].
- R10: When rate*mult is zero, the helper word is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock (core clock divided by two) |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_idx | input | 5 | Generator number, 1-based |
| wr_data | input | 32 | Control word |
| wr_err | output | 1 | One-cycle pulse after a write with an invalid index |
| tick | output | 16 | One-cycle tick per generator, bit k-1 for generator k |
| calc_rate | input | 32 | Requested rate for the helper |
| calc_mult | input | 8 | Oversampling multiplier for the helper |
| calc_word | output | 32 | Control word computed by the helper |

## Verification
A bad counter or prescaler state shows up as a tick in the wrong cycle. On the fast settings this happens within a few clocks. With a large field or the prescaler it can take up to 16*4096 clocks. So the bench compares every tick bit on every clock against a reference that tracks phase in integers, and it runs one maximum-field period. A bad control register or a load sent to the wrong generator shows up as a period change or a lost phase on a channel that should have stayed undisturbed. Helper faults are visible at once on the word output.

// File: rtl/brg_pkg.sv
// Package: shared control-word layout for the baud-rate generator bank.
// Assumes one fixed word layout used by both the helper and the channels.
package brg_pkg;
    parameter int WORD_W    = 32;
    parameter int FIELD_W   = 12;
    parameter int FIELD_LSB = 1;
    parameter int EN_BIT    = 16;
    parameter int PRE_BIT   = 0;
    parameter int PRE_RATIO = 16;
    localparam int PRE_SHIFT = $clog2(PRE_RATIO);
    localparam int FIELD_MAX = (1 << FIELD_W) - 1;

    typedef struct packed {
        logic               en;
        logic               pre;
        logic [FIELD_W-1:0] field;
    } brg_ctrl_t;
endpackage

// File: rtl/brg_prescale.sv
// Module: optional divide-by-RATIO prescaler for one generator.
// Produces a step strobe every clock when bypassed and every RATIO clocks
// when active. Assumes clear restarts the phase and run low holds it at zero.
module brg_prescale #(
    parameter int RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic div_on,
    output logic step
);
    localparam int CW = $clog2(RATIO);

    logic [CW-1:0] pre_q;

    // Prescale phase counter, held at zero when idle or bypassed.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run || !div_on) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Step strobe: every cycle when bypassed, at the last phase otherwise.
    always_comb begin
        step = run && (!div_on || (pre_q == CW'(RATIO - 1)));
    end
endmodule

// File: rtl/brg_channel.sv
// Module: one baud-rate generator, made of a control register, a prescaler
// and a divide-by-(F+1) counter. Assumes load is a single-cycle strobe.
// Each load restarts both counters from zero.
module brg_channel
    import brg_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] word,
    output logic              tick
);
    brg_ctrl_t          ctrl_q;
    logic [FIELD_W-1:0] cnt_q;
    logic               step;
    logic               tick_q;

    // Control register: captures enable, prescale flag and field on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (load) begin
            ctrl_q.en    <= word[EN_BIT];
            ctrl_q.pre   <= word[PRE_BIT];
            ctrl_q.field <= word[FIELD_LSB +: FIELD_W];
        end
    end

    brg_prescale #(.RATIO(PRE_RATIO)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (load),
        .run    (ctrl_q.en),
        .div_on (ctrl_q.pre),
        .step   (step)
    );

    // Main divider: counts prescaled steps from 0 to field, then wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || load || !ctrl_q.en) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= (cnt_q == ctrl_q.field) ? '0 : cnt_q + 1'b1;
        end
    end

    // Tick register: one pulse on the step that wraps the counter.
    always_ff @(posedge clk) begin
        if (!rst_n || load || !ctrl_q.en) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= step && (cnt_q == ctrl_q.field);
        end
    end

    assign tick = tick_q;

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= ctrl_q.field);

    p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q && !(ctrl_q.field == '0 && !ctrl_q.pre)) |=> !tick_q);

    p_pre_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q && ctrl_q.en && ctrl_q.pre) |=> !tick_q);

    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.en |-> (!tick_q && cnt_q == '0));
endmodule

// File: rtl/brg_word_calc.sv
// Module: combinational helper that builds a control word from a rate and
// an oversampling multiplier. Assumes SRC_HZ is the generator source clock.
// A zero product gives an all-zero word.
module brg_word_calc
    import brg_pkg::*;
#(
    parameter longint unsigned SRC_HZ = 100_000_000,
    parameter int RATE_W = 32,
    parameter int MULT_W = 8
) (
    input  logic [RATE_W-1:0] rate,
    input  logic [MULT_W-1:0] mult,
    output logic [WORD_W-1:0] word
);
    localparam int          PROD_W = RATE_W + MULT_W;
    localparam logic [63:0] SRC_L  = 64'(SRC_HZ);
    localparam logic [63:0] LIMIT  = 64'(FIELD_MAX + 1);

    logic [PROD_W-1:0]  prod;
    logic [63:0]        quot;
    logic [63:0]        div_adj;
    logic               use_pre;
    logic [FIELD_W-1:0] fld;

    // Ratio, prescale choice, even rounding and word packing.
    always_comb begin
        prod    = PROD_W'(rate) * PROD_W'(mult);
        quot    = (prod == '0) ? 64'd0 : SRC_L / 64'(prod);
        use_pre = quot > LIMIT;
        div_adj = use_pre ? (quot >> PRE_SHIFT) : (quot + 64'(quot[0]));
        fld     = FIELD_W'(div_adj - 64'd1);
        word    = '0;
        if (prod != '0) begin
            word[EN_BIT]                = 1'b1;
            word[PRE_BIT]               = use_pre;
            word[FIELD_LSB +: FIELD_W]  = fld;
        end
    end
endmodule

// File: rtl/brg_bank.sv
// Module: top of the baud-rate generator bank. Decodes 1-based write
// indices, refuses bad ones and instantiates one channel per generator
// plus the control-word helper. Assumes CORE_HZ is the engine clock, and the
// generators run from half of it.
module brg_bank
    import brg_pkg::*;
#(
    parameter int              NUM_GEN = 16,
    parameter longint unsigned CORE_HZ = 200_000_000,
    parameter int              RATE_W  = 32,
    parameter int              MULT_W  = 8,
    localparam int             IDX_W   = $clog2(NUM_GEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [WORD_W-1:0]  wr_data,
    output logic               wr_err,
    output logic [NUM_GEN-1:0] tick,
    input  logic [RATE_W-1:0]  calc_rate,
    input  logic [MULT_W-1:0]  calc_mult,
    output logic [WORD_W-1:0]  calc_word
);
    localparam longint unsigned SRC_HZ = CORE_HZ / 2;

    logic               idx_ok;
    logic [NUM_GEN-1:0] load;
    logic               err_q;

    // Index range check against 1..NUM_GEN.
    always_comb begin
        idx_ok = (wr_idx != '0) && (wr_idx <= IDX_W'(NUM_GEN));
    end

    // Reject flag: one cycle after a write with a bad index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= wr_en && !idx_ok;
        end
    end

    assign wr_err = err_q;

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_ch
        // Per-channel load strobe from the 1-based index.
        assign load[g] = wr_en && idx_ok && (wr_idx == IDX_W'(g + 1));

        brg_channel #(.DATA_W(WORD_W)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load[g]),
            .word  (wr_data),
            .tick  (tick[g])
        );
    end

    brg_word_calc #(
        .SRC_HZ (SRC_HZ),
        .RATE_W (RATE_W),
        .MULT_W (MULT_W)
    ) u_calc (
        .rate (calc_rate),
        .mult (calc_mult),
        .word (calc_word)
    );

    p_one_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load));

    p_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !idx_ok) |=> wr_err);

    p_even_div_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (calc_word[EN_BIT] && !calc_word[PRE_BIT]) |-> calc_word[FIELD_LSB]);

    p_pre_has_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        calc_word[PRE_BIT] |-> calc_word[EN_BIT]);
endmodule

// File: tb/brg_bank_bench.sv
module brg_bank_bench;
    localparam int N = 16;
    localparam longint SRC = 100_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        wr_err;
    logic [N-1:0] tick;
    logic [31:0] calc_rate = '0;
    logic [7:0]  calc_mult = '0;
    logic [31:0] calc_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string phase_tag = "R1";

    longint mctrl [N];
    longint mphase [N];
    logic [N-1:0] exp_tick = '0;
    logic exp_err = 1'b0;

    always #5 clk = ~clk;

    brg_bank u_brg_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_err(wr_err), .tick(tick),
        .calc_rate(calc_rate), .calc_mult(calc_mult), .calc_word(calc_word)
    );

    // Reference model: phase integers advanced at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < N; g++) begin
                mctrl[g] = 0; mphase[g] = 0;
            end
            exp_tick = '0; exp_err = 1'b0;
        end else begin
            exp_err = wr_en && (wr_idx < 1 || wr_idx > N);
            for (int g = 0; g < N; g++) begin
                if (wr_en && wr_idx == g + 1) begin
                    mctrl[g] = wr_data; mphase[g] = 0; exp_tick[g] = 1'b0;
                end else if (((mctrl[g] >> 16) & 1) == 0) begin
                    mphase[g] = 0; exp_tick[g] = 1'b0;
                end else begin
                    longint per;
                    per = (((mctrl[g] >> 1) & 4095) + 1) * (((mctrl[g] & 1) != 0) ? 16 : 1);
                    mphase[g]++;
                    if (mphase[g] == per) begin
                        exp_tick[g] = 1'b1; mphase[g] = 0;
                    end else begin
                        exp_tick[g] = 1'b0;
                    end
                end
            end
        end
    end

    function automatic string mode_tag(int g);
        if (((mctrl[g] >> 16) & 1) == 0) return "R5";
        return ((mctrl[g] & 1) != 0) ? "R4" : "R3";
    endfunction

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int g = 0; g < N; g++) begin
                checks++;
                if (tick[g] !== exp_tick[g]) begin
                    errors++;
                    $display("FAIL %s/%s gen %0d tick actual %b expected %b at %0t",
                             phase_tag, mode_tag(g), g + 1, tick[g], exp_tick[g], $time);
                end
            end
            checks++;
            if (wr_err !== exp_err) begin
                errors++;
                $display("FAIL R7 wr_err actual %b expected %b at %0t", wr_err, exp_err, $time);
            end
        end
    end

    task automatic wr(input int idx, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'(idx); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] ref_word(longint rate, longint mult);
        longint p, d;
        logic pre;
        p = rate * mult;
        if (p == 0) return 32'd0;
        d = SRC / p;
        pre = 1'b0;
        if (d > 4096) begin pre = 1'b1; d = d / 16; end
        if (!pre && (d % 2) != 0) d++;
        return 32'h0001_0000 | 32'(pre) | (32'((d - 1) & 4095) << 1);
    endfunction

    task automatic calc_check(input string tag, input longint rate, input longint mult);
        logic [31:0] e;
        @(negedge clk);
        calc_rate = 32'(rate); calc_mult = 8'(mult);
        #2;
        e = ref_word(rate, mult);
        checks++;
        if (calc_word !== e) begin
            errors++;
            $display("FAIL %s helper rate %0d mult %0d actual %h expected %h",
                     tag, rate, mult, calc_word, e);
        end
    endtask

    initial begin
        // R1: reset state, checked during and right after reset
        idle(2);
        checks++;
        if (tick !== '0 || wr_err !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs actual %h/%b expected 0/0", tick, wr_err);
        end
        rst_n = 1'b1;
        idle(3);

        phase_tag = "R3";
        wr(1, 32'h0001_0006);             // field 3, period 4
        wr(16, 32'h0001_0000);            // field 0, tick every cycle
        idle(40);

        phase_tag = "R4";
        wr(2, 32'h0001_0003);             // prescale, field 1, period 32
        idle(100);

        phase_tag = "R2";
        wr(3, 32'hFFFE_E004);             // ignored bits set, field 2, no prescale
        idle(30);

        phase_tag = "R6";
        wr(1, 32'h0001_000A);             // field 5 mid-run
        idle(9);
        wr(1, 32'h0001_000A);             // same word restarts phase
        idle(30);

        phase_tag = "R5";
        wr(16, 32'h0000_0000);
        wr(2, 32'h0000_0003);             // prescale and field but no enable
        idle(40);

        phase_tag = "R7";
        wr(0, 32'h0001_0000);
        wr(17, 32'h0001_0000);
        wr(31, 32'h0000_0000);
        idle(40);

        phase_tag = "R3 max field";
        wr(4, 32'h0001_1FFE);             // field 4095, period 4096
        idle(8300);

        calc_check("R8", 300, 8);         // large ratio -> prescale
        calc_check("R8", 1, 1);           // ratio beyond field after /16
        calc_check("R8", 24408, 1);       // ratio 4097 -> prescale
        calc_check("R9", 24414, 1);       // ratio 4096 stays unprescaled
        calc_check("R9", 9600, 16);       // odd ratio 651 -> 652
        calc_check("R9", 115200, 16);     // even ratio 54
        calc_check("R9", 12_500_000, 1);  // ratio 8
        calc_check("R9", 100_000_000, 2); // ratio 0 wraps field
        calc_check("R10", 0, 16);
        calc_check("R10", 9600, 0);

        idle(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule